// File: doc/BRIEF.md
# ADC Trigger Detector

This block sits on a dual-channel sample path. Two streams of 12-bit two's complement ADC samples arrive on every sample clock, together with two external trigger pins. For each channel the block evaluates a pin condition and an analog threshold condition, merges them according to a per-channel rule, and writes the result into the top bit of a 16-bit output word that also carries the sample. Because each flag travels in the same word as its sample, any later stage with an unknown pipeline depth keeps the two aligned without a side channel.

The modes, combine rules and signed limits are written through a small register port clocked by its own clock. Writes go to shadow registers and take effect only when a commit address is written. The commit then crosses into the sample domain through a toggle handshake, so every field of both channels switches on the same sample.

Top module: `adc_trig_detect`

## Requirements
- R1: Each output word carries the captured sample in bits 11:0, the channel trigger flag in bit 15 and zeros in bits 14:12. A sample present at one rising sample-clock edge appears on the output after the next rising edge.
- R2: Trigger pin 0 feeds only channel A and trigger pin 1 feeds only channel B.
- R3: Pin mode code 0 fires while the synchronized pin is high, and code 1 fires while it is low.
- R4: Pin mode code 2 fires on any pin change, code 3 on a low-to-high change and code 4 on a high-to-low change, each for a single cycle. Pins pass a two-flop synchronizer, so a pin change present at a rising edge shows on the output after the third rising edge.
- R5: Analog mode code 0 fires when the sample is strictly above the limit, and code 1 fires when it is strictly below. Both compare as signed 12-bit values.
- R6: Analog mode code 3 fires when the previous sample is at or below the limit and the current one is above it. Code 4 fires when the previous sample is at or above the limit and the current one is below it. Code 2 fires on either of these.
- R7: Combine code 0 uses the pin result alone, 1 the analog result alone, 2 their OR and 3 their AND.
- R8: Register address 2*ch holds the mode word for channel ch (ch 0 = A, ch 1 = B): pin mode in bits 2:0, analog mode in bits 6:4, combine in bits 9:8. Address 2*ch+1 holds the limit in bits 11:0. Written values have no effect until address 4 is written. After that commit, all fields of both channels change together.
- R9: After reset both output words are zero, and each channel uses pin mode 0, analog mode 0, combine 0 and limit 0.
- R10: Pin or analog mode codes 5 to 7 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleClk | input | 1 | Sample-domain clock |
| sampleRstN | input | 1 | Active-low asynchronous reset, sample domain |
| chanAData | input | 12 | Channel A sample, two's complement |
| chanBData | input | 12 | Channel B sample, two's complement |
| trigPins | input | 2 | Asynchronous trigger pins, bit 0 for A, bit 1 for B |
| cfgClk | input | 1 | Register-port clock |
| cfgRstN | input | 1 | Active-low asynchronous reset, register domain |
| cfgWrEn | input | 1 | Write strobe |
| cfgAddr | input | 3 | Write address |
| cfgWrData | input | 16 | Write data |
| chanAWord | output | 16 | Channel A sample with trigger flag |
| chanBWord | output | 16 | Channel B sample with trigger flag |

## Verification
A pin edge and an analog threshold hit can land on the same output word, and under the AND rule only that coincidence raises the flag. The bench forces the coincidence by driving the pin rise one cycle ahead of the above-limit sample, which makes up for the extra synchronizer stage. It then shifts the two apart by a cycle. The flag must be set only in the coincident word. The same offsets under the OR rule must set the flag in each word that holds either event.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int SAMPLE_W = 12;

  localparam logic [2:0] PIN_HIGH = 3'd0;
  localparam logic [2:0] PIN_LOW  = 3'd1;
  localparam logic [2:0] PIN_ANY  = 3'd2;
  localparam logic [2:0] PIN_RISE = 3'd3;
  localparam logic [2:0] PIN_FALL = 3'd4;

  localparam logic [2:0] ANA_ABOVE = 3'd0;
  localparam logic [2:0] ANA_BELOW = 3'd1;
  localparam logic [2:0] ANA_CROSS = 3'd2;
  localparam logic [2:0] ANA_UP    = 3'd3;
  localparam logic [2:0] ANA_DOWN  = 3'd4;

  typedef enum logic [1:0] {
    COMB_PIN = 2'd0,
    COMB_ANA = 2'd1,
    COMB_OR  = 2'd2,
    COMB_AND = 2'd3
  } combine_e;

  typedef struct packed {
    combine_e             combine;
    logic [2:0]           anaMode;
    logic [2:0]           pinMode;
    logic [SAMPLE_W-1:0]  limit;
  } chanCfg_t;

  localparam chanCfg_t RESET_CFG = '{combine: COMB_PIN, anaMode: ANA_ABOVE,
                                     pinMode: PIN_HIGH, limit: '0};

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
  } cfgStrobe_t;

endpackage

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3,
  parameter int CFG_DW = 16,
  parameter int DATA_W = SAMPLE_W
) (
  input  logic                    cfgClk,
  input  logic                    cfgRstN,
  input  logic                    cfgWrEn,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [CFG_DW-1:0]       cfgWrData,
  input  logic                    sampleClk,
  input  logic                    sampleRstN,
  output chanCfg_t [NUM_CH-1:0]   holdCfg,
  output cfgStrobe_t              strobe
);

  localparam int COMMIT_ADDR = 2 * NUM_CH;

  chanCfg_t [NUM_CH-1:0] shadowCfg;
  logic       reqTgl, pending, busy, launch, commitReq;
  logic [1:0] ackSync;
  logic [2:0] reqSync;
  logic       unusedWrBits;

  assign unusedWrBits = ^cfgWrData;

  // register-domain shadow registers
  always_ff @(posedge cfgClk or negedge cfgRstN) begin
    if (!cfgRstN) begin
      for (int c = 0; c < NUM_CH; c++) shadowCfg[c] <= RESET_CFG;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfgWrEn && cfgAddr == ADDR_W'(2 * c)) begin
          shadowCfg[c].pinMode <= cfgWrData[2:0];
          shadowCfg[c].anaMode <= cfgWrData[6:4];
          shadowCfg[c].combine <= combine_e'(cfgWrData[9:8]);
        end
        if (cfgWrEn && cfgAddr == ADDR_W'(2 * c + 1)) begin
          shadowCfg[c].limit <= cfgWrData[DATA_W-1:0];
        end
      end
    end
  end

  assign commitReq = cfgWrEn && (cfgAddr == ADDR_W'(COMMIT_ADDR));
  assign busy      = reqTgl ^ ackSync[1];
  assign launch    = (commitReq || pending) && !busy;

  // hold register stays frozen while a transfer is in flight
  always_ff @(posedge cfgClk or negedge cfgRstN) begin
    if (!cfgRstN) begin
      for (int c = 0; c < NUM_CH; c++) holdCfg[c] <= RESET_CFG;
      reqTgl  <= 1'b0;
      pending <= 1'b0;
      ackSync <= '0;
    end else begin
      ackSync <= {ackSync[0], reqSync[2]};
      if (launch) begin
        holdCfg <= shadowCfg;
        reqTgl  <= ~reqTgl;
        pending <= 1'b0;
      end else if (commitReq) begin
        pending <= 1'b1;
      end
    end
  end

  // sample-domain side of the toggle handshake
  always_ff @(posedge sampleClk or negedge sampleRstN) begin
    if (!sampleRstN) reqSync <= '0;
    else             reqSync <= {reqSync[1:0], reqTgl};
  end

  assign strobe.loadCfg = reqSync[1] ^ reqSync[2];

  p_hold_stable_r8: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    busy |=> $stable(holdCfg));

  p_single_load_r8: assert property (@(posedge sampleClk) disable iff (!sampleRstN)
    strobe.loadCfg |=> !strobe.loadCfg);

endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCfg_t          cfg,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              pinSync,
  output logic [OUT_W-1:0]  wordOut
);

  localparam int PAD_W = OUT_W - DATA_W - 1;

  logic signed [DATA_W-1:0] curS, prevS, limS;
  logic seenOne, primed, pinPrev;
  logic pinHit, anaHit, flag;
  logic curAbove, curBelow, prevAbove, prevBelow, upX, downX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curS    <= '0;
      prevS   <= '0;
      seenOne <= 1'b0;
      primed  <= 1'b0;
      pinPrev <= 1'b0;
    end else begin
      curS    <= $signed(sampleIn);
      prevS   <= curS;
      seenOne <= 1'b1;
      primed  <= seenOne;
      pinPrev <= pinSync;
    end
  end

  assign limS = $signed(cfg.limit);

  always_comb begin
    case (cfg.pinMode)
      PIN_HIGH: pinHit = pinSync;
      PIN_LOW:  pinHit = !pinSync;
      PIN_ANY:  pinHit = pinSync ^ pinPrev;
      PIN_RISE: pinHit = pinSync && !pinPrev;
      PIN_FALL: pinHit = !pinSync && pinPrev;
      default:  pinHit = 1'b0;
    endcase
  end

  assign curAbove  = curS > limS;
  assign curBelow  = curS < limS;
  assign prevAbove = prevS > limS;
  assign prevBelow = prevS < limS;
  assign upX       = primed && !prevAbove && curAbove;
  assign downX     = primed && !prevBelow && curBelow;

  always_comb begin
    case (cfg.anaMode)
      ANA_ABOVE: anaHit = curAbove;
      ANA_BELOW: anaHit = curBelow;
      ANA_CROSS: anaHit = upX || downX;
      ANA_UP:    anaHit = upX;
      ANA_DOWN:  anaHit = downX;
      default:   anaHit = 1'b0;
    endcase
  end

  always_comb begin
    case (cfg.combine)
      COMB_PIN: flag = pinHit;
      COMB_ANA: flag = anaHit;
      COMB_OR:  flag = pinHit || anaHit;
      default:  flag = pinHit && anaHit;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordOut <= '0;
    else       wordOut <= {flag, {PAD_W{1'b0}}, curS};
  end

  p_rise_after_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.pinMode == PIN_RISE && pinHit) |-> !$past(pinSync));

  p_fall_after_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.pinMode == PIN_FALL && pinHit) |-> $past(pinSync));

endmodule

// File: rtl/adc_trig_datapath.sv
module adc_trig_datapath
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DATA_W      = SAMPLE_W,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strobe,
  input  chanCfg_t [NUM_CH-1:0]          holdCfg,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  sampleIn,
  input  logic [NUM_CH-1:0]              pinIn,
  output logic [NUM_CH-1:0][OUT_W-1:0]   wordOut
);

  chanCfg_t [NUM_CH-1:0] activeCfg;
  logic [NUM_CH-1:0] syncChain [SYNC_STAGES];
  logic [1:0] warm;

  // all channels switch on one edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) activeCfg[c] <= RESET_CFG;
    end else if (strobe.loadCfg) begin
      activeCfg <= holdCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd2)  warm <= warm + 2'd1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    adc_trig_chan #(
      .DATA_W (DATA_W),
      .OUT_W  (OUT_W)
    ) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .cfg      (activeCfg[c]),
      .sampleIn (sampleIn[c]),
      .pinSync  (syncChain[SYNC_STAGES-1][c]),
      .wordOut  (wordOut[c])
    );

    p_data_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd2) |-> (wordOut[c][DATA_W-1:0] == $past(sampleIn[c], 2)));
  end

endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int OUT_W  = 16,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 16
) (
  input  logic              sampleClk,
  input  logic              sampleRstN,
  input  logic [DATA_W-1:0] chanAData,
  input  logic [DATA_W-1:0] chanBData,
  input  logic [1:0]        trigPins,
  input  logic              cfgClk,
  input  logic              cfgRstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgWrData,
  output logic [OUT_W-1:0]  chanAWord,
  output logic [OUT_W-1:0]  chanBWord
);

  localparam int NUM_CH = 2;

  chanCfg_t [NUM_CH-1:0]          holdCfg;
  cfgStrobe_t                     strobe;
  logic [NUM_CH-1:0][DATA_W-1:0]  sampleBus;
  logic [NUM_CH-1:0][OUT_W-1:0]   wordBus;

  assign sampleBus = {chanBData, chanAData};
  assign chanAWord = wordBus[0];
  assign chanBWord = wordBus[1];

  adc_trig_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (CFG_AW),
    .CFG_DW (CFG_DW),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .cfgClk     (cfgClk),
    .cfgRstN    (cfgRstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .sampleClk  (sampleClk),
    .sampleRstN (sampleRstN),
    .holdCfg    (holdCfg),
    .strobe     (strobe)
  );

  adc_trig_datapath #(
    .NUM_CH      (NUM_CH),
    .DATA_W      (DATA_W),
    .OUT_W       (OUT_W),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (sampleClk),
    .rstN     (sampleRstN),
    .strobe   (strobe),
    .holdCfg  (holdCfg),
    .sampleIn (sampleBus),
    .pinIn    (trigPins),
    .wordOut  (wordBus)
  );

endmodule

// File: tb/adc_trig_detect_tb_top.sv
module adc_trig_detect_tb_top;

  logic        sampleClk = 1'b0;
  logic        cfgClk = 1'b0;
  logic        sampleRstN = 1'b0;
  logic        cfgRstN = 1'b0;
  logic [11:0] chA = '0, chB = '0;
  logic [1:0]  pins = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] outA, outB;

  logic [15:0] histA [1024];
  logic [15:0] histB [1024];
  int step = 0;
  int checks = 0;
  int fails = 0;

  always #4 sampleClk = ~sampleClk;
  always #5 cfgClk = ~cfgClk;

  adc_trig_detect dut_i (
    .sampleClk  (sampleClk),
    .sampleRstN (sampleRstN),
    .chanAData  (chA),
    .chanBData  (chB),
    .trigPins   (pins),
    .cfgClk     (cfgClk),
    .cfgRstN    (cfgRstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .chanAWord  (outA),
    .chanBWord  (outB)
  );

  function automatic logic [15:0] mw(input int pinM, input int anaM, input int comb);
    logic [15:0] w;
    w = '0;
    w[2:0] = 3'(pinM);
    w[6:4] = 3'(anaM);
    w[9:8] = 2'(comb);
    return w;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkFlag(input string req, input logic [15:0] word, input logic exp);
    chk(req, {15'b0, word[15]}, {15'b0, exp});
  endtask

  // record outputs at this negedge, then drive the next sample
  task automatic push(input logic [11:0] a, input logic [11:0] b, input logic [1:0] p);
    @(negedge sampleClk);
    histA[step] = outA;
    histB[step] = outB;
    chA = a;
    chB = b;
    pins = p;
    step++;
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge cfgClk);
    cfgWrEn = 1'b1;
    cfgAddr = a;
    cfgWrData = d;
    @(negedge cfgClk);
    cfgWrEn = 1'b0;
  endtask

  task automatic commit();
    cfgWrite(3'd4, 16'h0);
    repeat (12) @(negedge sampleClk);
  endtask

  task automatic t_reset();
    @(negedge sampleClk);
    chk("R9 reset A", outA, 16'h0000);
    chk("R9 reset B", outB, 16'h0000);
  endtask

  task automatic t_layout();
    int b = step;
    push(12'h7FF, 12'h800, 2'b00);
    push(12'h123, 12'hFFF, 2'b00);
    push(12'h000, 12'h001, 2'b00);
    repeat (3) push(12'h000, 12'h000, 2'b00);
    chk("R1 word A0", histA[b+2], 16'h07FF);
    chk("R1 word B0", histB[b+2], 16'h0800);
    chk("R1 word A1", histA[b+3], 16'h0123);
    chk("R1 word B1", histB[b+3], 16'h0FFF);
    chk("R1 word A2", histA[b+4], 16'h0000);
    chk("R1 word B2", histB[b+4], 16'h0001);
  endtask

  task automatic t_pinLevel();
    int b, j;
    b = step;
    push(0, 0, 2'b00);
    push(0, 0, 2'b00);
    push(0, 0, 2'b01);
    push(0, 0, 2'b01);
    push(0, 0, 2'b00);
    repeat (4) push(0, 0, 2'b00);
    chkFlag("R3 R9 high A", histA[b+5], 1'b1);
    chkFlag("R3 high A held", histA[b+6], 1'b1);
    chkFlag("R3 high A released", histA[b+7], 1'b0);
    chkFlag("R2 pin0 not on B", histB[b+5], 1'b0);
    cfgWrite(3'd2, mw(1, 0, 0));
    commit();
    j = step;
    push(0, 0, 2'b10);
    push(0, 0, 2'b00);
    repeat (4) push(0, 0, 2'b00);
    chkFlag("R3 low B pin high", histB[j+3], 1'b0);
    chkFlag("R3 low B pin low", histB[j+4], 1'b1);
    chkFlag("R2 pin1 not on A", histA[j+3], 1'b0);
  endtask

  task automatic t_pinEdge();
    int b;
    cfgWrite(3'd0, mw(3, 0, 0));
    cfgWrite(3'd2, mw(4, 0, 0));
    commit();
    b = step;
    push(0, 0, 2'b00);
    push(0, 0, 2'b00);
    push(0, 0, 2'b11);
    push(0, 0, 2'b11);
    push(0, 0, 2'b00);
    push(0, 0, 2'b00);
    repeat (4) push(0, 0, 2'b00);
    chkFlag("R4 rise A", histA[b+5], 1'b1);
    chkFlag("R4 rise A one cycle", histA[b+6], 1'b0);
    chkFlag("R4 rise A not on fall", histA[b+7], 1'b0);
    chkFlag("R4 fall B not on rise", histB[b+5], 1'b0);
    chkFlag("R4 fall B", histB[b+7], 1'b1);
    chkFlag("R4 fall B one cycle", histB[b+8], 1'b0);
    cfgWrite(3'd0, mw(2, 0, 0));
    commit();
    b = step;
    push(0, 0, 2'b00);
    push(0, 0, 2'b01);
    push(0, 0, 2'b00);
    repeat (4) push(0, 0, 2'b00);
    chkFlag("R4 any up", histA[b+4], 1'b1);
    chkFlag("R4 any down", histA[b+5], 1'b1);
    chkFlag("R4 any idle", histA[b+6], 1'b0);
  endtask

  task automatic t_analog();
    int b;
    cfgWrite(3'd0, mw(0, 0, 1));
    cfgWrite(3'd1, 16'h0FFB);
    cfgWrite(3'd2, mw(0, 1, 1));
    cfgWrite(3'd3, 16'd10);
    commit();
    b = step;
    push(12'hFFA, 12'h800, 2'b00);
    push(12'hFFB, 12'd10, 2'b00);
    push(12'hFFC, 12'd9, 2'b00);
    push(12'd100, 12'd11, 2'b00);
    repeat (3) push(0, 0, 2'b00);
    chkFlag("R5 above -6 vs -5", histA[b+2], 1'b0);
    chkFlag("R5 above equal", histA[b+3], 1'b0);
    chkFlag("R5 above -4", histA[b+4], 1'b1);
    chkFlag("R5 above 100", histA[b+5], 1'b1);
    chkFlag("R5 below -2048", histB[b+2], 1'b1);
    chkFlag("R5 below equal", histB[b+3], 1'b0);
    chkFlag("R5 below 9", histB[b+4], 1'b1);
    chkFlag("R5 below 11", histB[b+5], 1'b0);
  endtask

  task automatic t_cross();
    int b;
    cfgWrite(3'd0, mw(0, 3, 1));
    cfgWrite(3'd1, 16'h0);
    cfgWrite(3'd2, mw(0, 4, 1));
    cfgWrite(3'd3, 16'h0);
    commit();
    b = step;
    push(12'hFFD, 12'd5, 2'b00);
    push(12'd0, 12'd0, 2'b00);
    push(12'd1, 12'hFFF, 2'b00);
    push(12'd2, 12'hFFE, 2'b00);
    push(12'hFFF, 12'd3, 2'b00);
    push(12'd1, 12'd3, 2'b00);
    repeat (3) push(12'd1, 12'd3, 2'b00);
    chkFlag("R6 up to limit only", histA[b+3], 1'b0);
    chkFlag("R6 up from limit", histA[b+4], 1'b1);
    chkFlag("R6 up stays above", histA[b+5], 1'b0);
    chkFlag("R6 up falling", histA[b+6], 1'b0);
    chkFlag("R6 up from below", histA[b+7], 1'b1);
    chkFlag("R6 down to limit only", histB[b+3], 1'b0);
    chkFlag("R6 down from limit", histB[b+4], 1'b1);
    chkFlag("R6 down stays below", histB[b+5], 1'b0);
    chkFlag("R6 down ignores rise", histB[b+6], 1'b0);
    cfgWrite(3'd2, mw(0, 2, 1));
    commit();
    b = step;
    push(12'd0, 12'd4, 2'b00);
    push(12'd0, 12'hFFC, 2'b00);
    push(12'd0, 12'hFFC, 2'b00);
    push(12'd0, 12'd7, 2'b00);
    repeat (3) push(12'd0, 12'd7, 2'b00);
    chkFlag("R6 either down", histB[b+3], 1'b1);
    chkFlag("R6 either steady", histB[b+4], 1'b0);
    chkFlag("R6 either up", histB[b+5], 1'b1);
  endtask

  task automatic t_combine();
    int b;
    cfgWrite(3'd0, mw(3, 0, 3));
    cfgWrite(3'd1, 16'h0);
    commit();
    b = step;
    push(12'hFFF, 0, 2'b00);
    push(12'hFFF, 0, 2'b01);
    push(12'd5, 0, 2'b01);
    push(12'd5, 0, 2'b00);
    repeat (4) push(12'hFFF, 0, 2'b00);
    chkFlag("R7 AND coincident", histA[b+4], 1'b1);
    chkFlag("R7 AND analog only", histA[b+5], 1'b0);
    b = step;
    push(12'd5, 0, 2'b00);
    push(12'd5, 0, 2'b01);
    push(12'hFFE, 0, 2'b01);
    push(12'hFFE, 0, 2'b00);
    repeat (4) push(12'hFFE, 0, 2'b00);
    chkFlag("R7 AND pin only", histA[b+4], 1'b0);
    chkFlag("R7 AND analog only 2", histA[b+3], 1'b0);
    cfgWrite(3'd0, mw(3, 0, 2));
    commit();
    b = step;
    push(12'd5, 0, 2'b00);
    push(12'd5, 0, 2'b01);
    push(12'hFFE, 0, 2'b01);
    push(12'hFFE, 0, 2'b00);
    repeat (4) push(12'hFFE, 0, 2'b00);
    chkFlag("R7 OR analog", histA[b+3], 1'b1);
    chkFlag("R7 OR pin", histA[b+4], 1'b1);
    chkFlag("R7 OR neither", histA[b+5], 1'b0);
  endtask

  task automatic t_commit();
    int b;
    // A is OR(rise, above 0); stage pin-high without commit
    cfgWrite(3'd0, mw(0, 0, 0));
    b = step;
    repeat (6) push(12'hFFF, 0, 2'b01);
    chkFlag("R8 no effect before commit", histA[b+4], 1'b0);
    chkFlag("R8 no effect before commit 2", histA[b+5], 1'b0);
    commit();
    b = step;
    repeat (3) push(12'hFFF, 0, 2'b01);
    chkFlag("R8 effect after commit", histA[b+1], 1'b1);
    cfgWrite(3'd0, mw(5, 0, 0));
    commit();
    b = step;
    repeat (4) push(12'hFFF, 0, 2'b01);
    chkFlag("R10 pin code 5", histA[b+3], 1'b0);
    cfgWrite(3'd0, mw(0, 6, 1));
    cfgWrite(3'd1, 16'h0);
    commit();
    b = step;
    repeat (4) push(12'd100, 0, 2'b01);
    chkFlag("R10 analog code 6", histA[b+3], 1'b0);
    chk("R10 data still passes", {4'h0, histA[b+3][11:0]}, 16'd100);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge sampleClk);
    sampleRstN = 1'b1;
    cfgRstN = 1'b1;
    repeat (3) @(negedge sampleClk);
    t_reset();
    t_layout();
    t_pinLevel();
    t_pinEdge();
    t_analog();
    t_cross();
    t_combine();
    t_commit();
    finishRun();
  end

endmodule